// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles, equal to the depth of an internal two-port storage array. Words are never copied from one location to another. Each word is written once into the array and read once, DEPTH cycles later, from the same location. A write pointer and a read pointer sweep the array in lockstep, one entry per cycle. This costs one array entry per cycle of delay plus two small counters. A flip-flop cascade of the same length would switch every stage on every cycle.

The stream advances on every clock edge. There is no input qualifier and no ready signal, so the block never applies back-pressure and the upstream source must present a word on every cycle. The downstream side must accept a word on every cycle. The array is not cleared by reset, so the output carries a validity flag. This flag stays low until the first word written after reset has crossed the whole line. DEPTH must be a power of two and at least 2, so that both pointers wrap naturally.

Top module: `sram_delay_line`

## Requirements
- R1: Once `dout_valid` is high, `dout` after rising edge n equals the `din` word sampled at rising edge n−DEPTH.
- R2: Reset sets the read pointer to entry 0. As a result, the first valid output after reset is the first word sampled after reset.
- R3: Reset sets the write pointer to the last entry (all ones), one entry behind the read pointer.
- R4: Both pointers advance by exactly one entry on every non-reset edge and wrap from the last entry to entry 0, so the delay holds across any number of sweeps.
- R5: The write pointer always trails the read pointer by exactly one entry (modulo DEPTH).
- R6: While reset is held, `dout_valid` and `dout` are 0. With edge 1 taken as the first rising edge at which reset is low, `dout_valid` first rises after edge DEPTH+1.
- R7: Once high, `dout_valid` stays high until the next reset.
- R8: A reset in the middle of the stream discards all words in flight. The line refills from the first word sampled after the reset and follows R6 again.
- R9: The line never stalls. Consecutive input words, including repeated and alternating values, come out on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Input word, sampled on every rising edge |
| dout | output | DATA_W | Word delayed by DEPTH cycles |
| dout_valid | output | 1 | High when `dout` carries a word written after the last reset |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 12. With a short depth, a single run covers many full pointer sweeps and wraps, several fill phases after reset, and a reset landing halfway through a fill. The 12-bit width keeps a ramp from repeating within the window a pointer error would expose, so off-by-one delays appear as data mismatches. The first-valid edge is checked at exactly DEPTH+1 edges after every reset release.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic {
    FILL_PHASE   = 1'b0,
    STREAM_PHASE = 1'b1
  } fill_phase_e;
endpackage

// File: rtl/sdl_ptr.sv
module sdl_ptr #(
  parameter int AW       = 6,
  parameter bit RST_ONES = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] rst_val;
  logic [AW-1:0] ptr_q;

  generate
    if (RST_ONES) begin : g_last
      assign rst_val = '1;
    end else begin : g_first
      assign rst_val = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= rst_val;
    else     ptr_q <= ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // assertion-only tracking: one non-reset edge seen
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  // R4: one-entry step each cycle, natural wrap
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (ptr_q == AW'($past(ptr_q) + 1'b1)));
endmodule

// File: rtl/sdl_array.sv
module sdl_array #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ENTRIES = 1 << AW;

  logic [DATA_W-1:0] store [ENTRIES];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    store[wr_addr] <= wr_data;
    rd_q           <= store[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sdl_fill.sv
module sdl_fill
  import sdl_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_live
);
  fill_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= FILL_PHASE;
    else if (phase_q == FILL_PHASE && rd_addr == '1)
      phase_q <= STREAM_PHASE;
  end

  assign rd_live = (phase_q == STREAM_PHASE);

  // R6: filling ends only after the read pointer reaches the last entry
  assert_fill_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == FILL_PHASE && rd_addr != '1) |=> (phase_q == FILL_PHASE));
endmodule

// File: rtl/sram_delay_line.sv
module sram_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  localparam int AW     = $clog2(DEPTH);
  localparam int AGE_W  = AW + 2;
  localparam int AGE_MX = DEPTH + 1;

  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              rd_live;
  logic [DATA_W-1:0] dout_q;
  logic              valid_q;

  sdl_ptr #(.AW(AW), .RST_ONES(1'b1)) u_wr_ptr (
    .clk (clk),
    .rst (rst),
    .ptr (wr_addr)
  );

  sdl_ptr #(.AW(AW), .RST_ONES(1'b0)) u_rd_ptr (
    .clk (clk),
    .rst (rst),
    .ptr (rd_addr)
  );

  sdl_array #(.DATA_W(DATA_W), .AW(AW)) u_array (
    .clk     (clk),
    .wr_addr (wr_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  sdl_fill #(.AW(AW)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_live (rd_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      dout_q  <= rd_data;
      valid_q <= rd_live;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = valid_q;

  // assertion-only age counter: non-reset edges since reset, saturating
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                       age_q <= '0;
    else if (age_q != AGE_W'(AGE_MX)) age_q <= age_q + 1'b1;
  end

  // R2
  assert_rd_reset_R2: assert property (@(posedge clk)
    rst |=> (rd_addr == '0));
  // R3
  assert_wr_reset_R3: assert property (@(posedge clk)
    rst |=> (wr_addr == '1));
  // R5
  assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (rst)
    AW'(wr_addr + 1'b1) == rd_addr);
  // R6
  assert_valid_time_R6: assert property (@(posedge clk) disable iff (rst)
    dout_valid == (age_q == AGE_W'(AGE_MX)));
  // R7
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid);
endmodule

// File: tb/tb_sram_delay_line.sv
module tb_sram_delay_line;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int DW         = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] sb[$];
  int since_rst = 0;

  sram_delay_line #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reset held for some edges; outputs must be cleared (R6, R8)
  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    sb.delete();
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(dout_valid == 1'b0, "R6 valid low in reset", int'(dout_valid), 0);
      check(dout == '0, "R8 dout cleared in reset", int'(dout), 0);
    end
    rst = 1'b0;
    since_rst = 0;
  endtask

  // driver pushes, monitor pops and compares after the edge
  task automatic step(input logic [DW-1:0] v);
    logic [DW-1:0] exp;
    din = v;
    sb.push_back(v);
    @(posedge clk);
    @(negedge clk);
    since_rst++;
    if (sb.size() > DEPTH) begin
      exp = sb.pop_front();
      // R2/R3: first valid word is the first word after reset; R6/R7 timing
      check(dout_valid == 1'b1, "R6/R7 valid high", int'(dout_valid), 1);
      // R1 latency, R4 wrap, R5 gap, R9 ordering
      check(dout == exp, "R1 delayed data", int'(dout), int'(exp));
    end else begin
      check(dout_valid == 1'b0, "R6 valid low while filling", int'(dout_valid), 0);
    end
  endtask

  initial begin
    logic [DW-1:0] lfsr;
    do_reset(3);
    // ramp over several sweeps: R1, R4, R9
    for (int i = 0; i < 5*DEPTH; i++) step(DW'(i + 1));
    // alternating and repeated values: R9
    for (int i = 0; i < 2*DEPTH; i++) step((i % 2 == 0) ? DW'('hA5A) : DW'('h5A5));
    for (int i = 0; i < DEPTH; i++) step(DW'('h777));
    // mid-stream reset during a fill: R8
    do_reset(2);
    for (int i = 0; i < DEPTH/2; i++) step(DW'('h100 + i));
    do_reset(1);
    // pseudo-random stream after refill: R1, R2, R3, R6
    lfsr = DW'('h3C1);
    for (int i = 0; i < 6*DEPTH; i++) begin
      lfsr = {lfsr[DW-2:0], lfsr[DW-1] ^ lfsr[DW-4] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr);
    end
    // reset right after streaming, then a short refill: R8, R7
    do_reset(2);
    for (int i = 0; i < 2*DEPTH + 3; i++) step(DW'('hF00 - i));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule